// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block receives asynchronous serial characters on a single line, idle high. A one-cycle oversample tick, sixteen per bit time by default, paces all sampling. The line is first brought into the clock domain through a short synchronizer. A falling edge on an armed, idle line starts a candidate frame. Every bit is then judged by a two-of-three vote taken around its centre. Frames carry 8 or 9 bits, least significant first, followed by one stop bit. Each accepted character lands in a single data register, and a set of status flags describes it.

An all-zero character whose stop position is also zero is a break, and it is reported as its own event. It raises a one-cycle break pulse, sets the framing error flag and forces the data register to zero. It sets the data-full flag only when the watermark mode is 00.

The host takes the character and clears the flags with a one-cycle acknowledge. A frame that completes while the register is still full is dropped, and only the overrun flag records it.

Top module: `uart_rx_brk`

## Requirements
- R1: After a falling edge on an armed idle line, the start bit is judged by the majority of samples taken at oversample counts 7, 8 and 9. If the majority is one, the receiver returns to idle with no flag change and with `rx_active` staying low.
- R2: Data bits arrive least significant bit first; there are 9 when `nine_bit` is 1 and 8 otherwise. An accepted non-break frame loads `rx_data`, with bit 8 zero in 8-bit mode, and sets `data_full`.
- R3: Each bit value is the majority of its three centre samples. The noise flag of an accepted frame is set when any bit of that frame, from start to stop, had samples that disagreed.
- R4: When `par_en` is 1, the last received bit is an even parity bit over the whole character, and it is kept in `rx_data`. `par_err` is set when the count of ones among all received bits is odd. When `par_en` is 0, `par_err` is cleared on acceptance.
- R5: A stop bit voted zero sets `frame_err`; a stop bit voted one clears it on acceptance.
- R6: A frame whose data bits are all zero and whose stop bit is zero is a break. It raises `brk_pulse` for exactly one clock, sets `frame_err` and leaves `rx_data` at zero.
- R7: A break sets `data_full` only when `wm_sel` is 2'b00. For any other `wm_sel` value a break leaves `data_full` clear.
- R8: A frame that completes while `data_full` is set sets `ovr_err`. It leaves `rx_data`, `par_err` and `noise_err` unchanged. If that frame is a break, it still sets `frame_err` and zeroes `rx_data`.
- R9: `rx_active` is high from the validated start bit until the stop bit is sampled. The accepted-frame flags update one clock after `rx_active` falls.
- R10: After every frame, and after a break in particular, a new start is only recognised once the line has been sampled high. A line held low after a break starts no frame.
- R11: `rd_ack` clears `data_full`, `frame_err`, `par_err`, `noise_err` and `ovr_err` on the next clock edge.
- R12: After reset, all flags, `rx_data`, `rx_active` and `brk_pulse` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversample tick, one pulse per 1/16 bit |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| par_en | input | 1 | Last bit is an even parity bit |
| wm_sel | input | 2 | Watermark mode; 00 lets a break set data-full |
| rd_ack | input | 1 | Consume data register and clear flags |
| rx_data | output | 9 | Received character |
| data_full | output | 1 | Data register holds an unread character |
| frame_err | output | 1 | Stop bit sampled low |
| par_err | output | 1 | Parity mismatch |
| ovr_err | output | 1 | Frame dropped because the register was full |
| noise_err | output | 1 | Sample disagreement seen in the frame |
| rx_active | output | 1 | Frame in progress |
| brk_pulse | output | 1 | One-clock break indication |

## Verification
A frame's results are due one clock after the tick that takes the third stop-bit sample. That is roughly ten ticks into the stop bit plus about two clocks of synchronizer delay. The bench therefore compares the flags and data register only after a further full idle bit, so the exact sampling phase cannot shift a result into the check window. `rx_active` is compared at the end of the first data bit, well past the start validation and well before the stop sample. Break pulses are counted by a monitor on every edge and compared against the expected count at the same time as the flags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  localparam int CHAR_MAX = 9;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int CW    = 4,
  parameter int FIRST = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          din,
  output logic          bit_val,
  output logic          disagree
);
  localparam logic [CW-1:0] PT_A = CW'(FIRST);
  localparam logic [CW-1:0] PT_B = CW'(FIRST + 1);

  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (cnt == PT_A) s_a <= din;
      if (cnt == PT_B) s_b <= din;
    end
  end

  // third sample is the live input on the closing tick
  assign bit_val  = (s_a & s_b) | (s_a & din) | (s_b & din);
  assign disagree = !((s_a == s_b) && (s_b == din));
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rxd_s,
  input  logic                nine_bit,
  output logic                done,
  output logic [CHAR_MAX-1:0] data,
  output logic                stop_val,
  output logic                noisy,
  output logic                active
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] P_LO  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] P_HI  = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] P_END = CW'(OSR - 1);

  rx_state_e           state;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [CHAR_MAX-1:0] sh;
  logic                nacc, armed, nb_q;
  logic                vbit, vnoise;

  rx_vote #(.CW(CW), .FIRST(OSR/2 - 1)) u_vote (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .din(rxd_s),
    .bit_val(vbit), .disagree(vnoise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      nacc <= 1'b0; armed <= 1'b0; nb_q <= 1'b0;
      done <= 1'b0; data <= '0; stop_val <= 1'b1; noisy <= 1'b0; active <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (rxd_s) armed <= 1'b1;
            else if (armed) begin
              state <= RX_START; cnt <= CW'(1); nacc <= 1'b0;
              sh <= '0; nb_q <= nine_bit;
            end
          end
          RX_START: begin
            cnt <= cnt + 1'b1;
            if (cnt == P_HI) begin
              if (vbit) begin
                state <= RX_IDLE; armed <= 1'b0;
              end else begin
                active <= 1'b1; nacc <= vnoise;
              end
            end
            if (cnt == P_END) begin
              state <= RX_DATA; cnt <= '0; idx <= '0;
            end
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == P_HI) begin
              sh[idx] <= vbit;
              nacc <= nacc | vnoise;
            end
            if (cnt == P_END) begin
              cnt <= '0;
              if (idx == (nb_q ? 4'd8 : 4'd7)) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end
          end
          RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == P_HI) begin
              done <= 1'b1; data <= sh; stop_val <= vbit;
              noisy <= nacc | vnoise; active <= 1'b0;
              state <= RX_IDLE; armed <= 1'b0; cnt <= '0;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                os_tick,
  input  logic                rxd,
  input  logic                nine_bit,
  input  logic                par_en,
  input  logic [1:0]          wm_sel,
  input  logic                rd_ack,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                data_full,
  output logic                frame_err,
  output logic                par_err,
  output logic                ovr_err,
  output logic                noise_err,
  output logic                rx_active,
  output logic                brk_pulse
);
  logic                rxd_s;
  logic                f_done, f_stop, f_noise;
  logic [CHAR_MAX-1:0] f_data;
  logic                is_brk, par_bad, full_now;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .tick(os_tick), .rxd_s(rxd_s), .nine_bit(nine_bit),
    .done(f_done), .data(f_data), .stop_val(f_stop), .noisy(f_noise),
    .active(rx_active)
  );

  assign is_brk   = (f_data == '0) && !f_stop;
  assign par_bad  = par_en && (^f_data);
  assign full_now = data_full && !rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0; data_full <= 1'b0; frame_err <= 1'b0; par_err <= 1'b0;
      ovr_err <= 1'b0; noise_err <= 1'b0; brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= 1'b0;
      if (rd_ack) begin
        data_full <= 1'b0; frame_err <= 1'b0; par_err <= 1'b0;
        ovr_err <= 1'b0; noise_err <= 1'b0;
      end
      if (f_done) begin
        brk_pulse <= is_brk;
        if (full_now) begin
          ovr_err <= 1'b1;
          if (is_brk) begin
            frame_err <= 1'b1;
            rx_data   <= '0;
          end
        end else begin
          rx_data   <= is_brk ? '0 : f_data;
          data_full <= !is_brk || (wm_sel == 2'b00);
          frame_err <= !f_stop;
          par_err   <= par_bad;
          noise_err <= f_noise;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_ack,
  input logic [1:0] wm_sel,
  input logic [8:0] rx_data,
  input logic       data_full,
  input logic       frame_err,
  input logic       ovr_err,
  input logic       rx_active,
  input logic       brk_pulse
);
  assert_brk_flags_R6: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> (frame_err && rx_data == 9'd0));

  assert_brk_full_R7: assert property (@(posedge clk) disable iff (rst)
    (brk_pulse && $past(wm_sel) == 2'b00) |-> data_full);

  assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovr_err) && !brk_pulse) |-> $stable(rx_data));

  assert_full_after_active_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(data_full) |-> $past(rx_active, 2));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_err) |-> $past(rd_ack));
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst(rst), .rd_ack(rd_ack), .wm_sel(wm_sel), .rx_data(rx_data),
  .data_full(data_full), .frame_err(frame_err), .ovr_err(ovr_err),
  .rx_active(rx_active), .brk_pulse(brk_pulse)
);

// File: tb/uart_rx_brk_test.sv
module uart_rx_brk_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic nine_bit = 1'b0;
  logic par_en = 1'b0;
  logic [1:0] wm_sel = 2'b00;
  logic rd_ack = 1'b0;
  logic [8:0] rx_data;
  logic data_full, frame_err, par_err, ovr_err, noise_err, rx_active, brk_pulse;

  int total = 0, bad = 0, cyc = 0, brk_seen = 0, brk_exp = 0;
  logic [1:0] tdiv = 2'd0;
  logic [8:0] m_data = 9'd0;
  logic m_full = 0, m_fe = 0, m_pe = 0, m_nf = 0, m_ovr = 0;

  always #2.5 clk = ~clk;

  uart_rx_brk uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .nine_bit(nine_bit),
    .par_en(par_en), .wm_sel(wm_sel), .rd_ack(rd_ack), .rx_data(rx_data),
    .data_full(data_full), .frame_err(frame_err), .par_err(par_err),
    .ovr_err(ovr_err), .noise_err(noise_err), .rx_active(rx_active),
    .brk_pulse(brk_pulse)
  );

  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && brk_pulse) brk_seen <= brk_seen + 1;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line_bit(input logic v, input bit glitch);
    for (int k = 0; k < 64; k++) begin
      rxd = (glitch && k >= 32 && k < 36) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    m_full = 0; m_fe = 0; m_pe = 0; m_nf = 0; m_ovr = 0;
    chk("R11 full cleared", data_full, 0);
    chk("R11 ovr cleared", ovr_err, 0);
  endtask

  function automatic logic [8:0] mask_char(input logic [8:0] d, input bit nb);
    return nb ? d : {1'b0, d[7:0]};
  endfunction

  task automatic model_frame(input logic [8:0] dm, input logic stopv, input bit noisy);
    bit brk;
    brk = (dm == 9'd0) && !stopv;
    if (brk) brk_exp++;
    if (m_full) begin
      m_ovr = 1;
      if (brk) begin m_fe = 1; m_data = 9'd0; end
    end else begin
      m_data = brk ? 9'd0 : dm;
      m_full = !brk || (wm_sel == 2'b00);
      m_fe   = !stopv;
      m_pe   = par_en && (^dm);
      m_nf   = noisy;
    end
  endtask

  task automatic compare(input bit brk);
    chk(brk ? "R6 data zeroed" : "R2 data", rx_data, m_data);
    chk(brk ? "R7 full on break" : "R2 full", data_full, m_full);
    chk(brk ? "R6 frame error" : "R5 frame error", frame_err, m_fe);
    chk("R4 parity", par_err, m_pe);
    chk("R3 noise", noise_err, m_nf);
    chk("R8 overrun", ovr_err, m_ovr);
    chk("R6 break pulses", brk_seen, brk_exp);
  endtask

  task automatic send(input bit nb, input logic [8:0] d, input logic stopv,
                      input int gidx, input bit hold_low);
    logic [8:0] dm;
    dm = mask_char(d, nb);
    nine_bit = nb;
    line_bit(1'b0, 1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) begin
      line_bit(dm[i], gidx == i);
      if (i == 0) chk("R9 active mid-frame", rx_active, 1);
    end
    line_bit(stopv, 1'b0);
    if (hold_low) begin
      rxd = 1'b0;
      repeat (400) @(negedge clk);
      chk("R10 no start while low", rx_active, 0);
    end
    line_bit(1'b1, 1'b0);
    line_bit(1'b1, 1'b0);
    chk("R9 active after frame", rx_active, 0);
    model_frame(dm, stopv, gidx >= 0);
    compare((dm == 9'd0) && !stopv);
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 data", rx_data, 0);
    chk("R12 full", data_full, 0);
    chk("R12 flags", {frame_err, par_err, ovr_err, noise_err}, 0);
    chk("R12 active", rx_active, 0);
    line_bit(1'b1, 1'b0);

    // R1 false start: short low pulse
    rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
    repeat (32) @(negedge clk);
    chk("R1 false start active", rx_active, 0);
    line_bit(1'b1, 1'b0);
    chk("R1 false start full", data_full, 0);

    // R2 8-bit frame, R4 parity error (odd ones)
    par_en = 1'b1;
    send(1'b0, 9'h0A7, 1'b1, -1, 1'b0);
    ack();
    // R3 noisy 9-bit frame
    par_en = 1'b0;
    send(1'b1, 9'h15A, 1'b1, 3, 1'b0);
    ack();
    // R5 framing error with nonzero data
    send(1'b0, 9'h055, 1'b0, -1, 1'b0);
    ack();
    // R7 break, watermark 01: no full
    wm_sel = 2'b01;
    send(1'b0, 9'h000, 1'b0, -1, 1'b0);
    ack();
    // R6 R7 R10 break, watermark 00, line held low afterwards
    wm_sel = 2'b00;
    send(1'b1, 9'h000, 1'b0, -1, 1'b1);
    ack();
    // R8 overrun: second frame dropped
    send(1'b0, 9'h03C, 1'b1, -1, 1'b0);
    send(1'b0, 9'h0C3, 1'b1, -1, 1'b0);
    // R8 break while full
    send(1'b0, 9'h000, 1'b0, -1, 1'b0);
    ack();

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [8:0] d;
      logic sv;
      int g;
      bit nb;
      nb     = $urandom % 2;
      par_en = $urandom % 2;
      wm_sel = 2'($urandom % 4);
      d      = 9'($urandom);
      sv     = ($urandom % 8) != 0;
      if ($urandom % 6 == 0) begin d = 9'd0; sv = 1'b0; end
      g = ($urandom % 5 == 0) ? int'($urandom % 8) : -1;
      if ($urandom % 2 == 0) ack();
      send(nb, d, sv, g, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule